// File: doc/BRIEF.md
# Clock and Sync Routing Matrix for a Four-Port Framer Group

This block sits between four T1/E1 framer ports, three reference clocks (1.544 MHz, 2.048 MHz and 8.192 MHz) and a single PCM backplane bus. A host programs it through a byte-wide register interface. Some registers are read-only and identify the board. The read/write control registers set, port by port, where each framer's master clock, transmit clock, transmit and receive system clocks, sync pins and transmit serial data come from. They also set which port sources each PCM bus clock, sync and receive-data line.

Every routing path is a combinational selector driven by registered configuration. A new setting therefore takes effect on the clock edge that captures the host write. Pins that a setting leaves undriven are reported with an output-enable bit that is low. The data bit next to it is then held at 0, and the pad can be tri-stated with a weak pulldown so that the framer can drive that pin itself. A host read returns data one clock after the address is presented. Reads have no side effects.

Top module: `sync_route_matrix`

## Requirements
- R1: Read-only identity offsets return 0x0D at 0x00, 0x00 at 0x02, 0x01 at 0x03 and 0x06 at 0x04. Offsets 0x05, 0x06 and 0x07 return the board, assembly and logic revision parameters (0x01, 0x02 and 0x03 by default). Writes to these offsets change nothing. `host_rdata` shows the value for the address that was sampled on the previous rising edge.
- R2: Any offset not listed in R1 or R3 reads as 0x00, and writing it has no effect on any output.
- R3: Reset puts 0x03 in the master clock register (0x11) and 0x00 in every other control register. A control register reads back its written value masked by 0x11:0x03, 0x12–0x14:0xFF, 0x15–0x16:0x0F, 0x17:0x3F, 0x18:0xFF, 0x19:0x0F, 0x1A:0x33, 0x1B:0x77.
- R4: Register 0x11 bit 0 selects the master clock for ports 1 and 3 (`mclk_out[0]`). Bit 1 selects the master clock for ports 2 and 4 (`mclk_out[1]`). A 0 selects the 1.544 MHz reference and a 1 selects the 2.048 MHz reference.
- R5: Register 0x12 holds one 2-bit code per port, with port n in bits 2n+1:2n (ports counted from 0). Code 00 gives the 1.544 MHz reference on the transmit clock, 01 gives the 2.048 MHz reference, and 10 gives the port's own recovered receive clock. Code 11 holds the transmit clock low.
- R6: Registers 0x13 (transmit system clock) and 0x14 (receive system clock) use the same per-port field layout as R5. Code 00 selects 1.544 MHz, 01 selects 2.048 MHz, 10 selects 8.192 MHz, and 11 selects the port's backplane clock.
- R7: Registers 0x15 (transmit sync) and 0x16 (transmit elastic-store sync) hold one bit per port, with port n in bit n. A 1 drives the pin from the same port's receive sync with the enable high. A 0 sets the enable low and the data bit to 0.
- R8: In register 0x17, bits 3:0 are per-port enables for the receive sync pins and bits 5:4 name the master port (0–3). An enabled port's pin is driven with the master port's receive sync. A disabled port's pin has the enable low and the data bit at 0.
- R9: Register 0x18 holds one 2-bit code per port for transmit serial data, with port n in bits 2n+1:2n. Code 01 loops the port's receive data back with the enable high, and 10 drives `pcm_txd` with the enable high. Codes 00 and 11 set the enable low and the data bit to 0.
- R10: `pcm_rxd` is the logical OR of the receive data of every port whose bit is set in register 0x19. It is 0 when no bit is set.
- R11: Register 0x1A bits 1:0 select which port's receive sync drives `pcm_rsync`. Bits 5:4 select which port's transmit sync drives `pcm_tsync`.
- R12: Register 0x1B bits 2:0 select `pcm_rclk`. Bit 2 set takes port[1:0]'s backplane clock, and bit 2 clear takes that port's recovered receive clock. Bits 6:4 select `pcm_tclk`. Bit 6 set takes the backplane clock, and bit 6 clear takes the transmit clock that R5 selected for that port. For example, 0x44 puts port 0's backplane clock on both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host interface clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Register offset |
| host_we | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| ref_1m544 | input | 1 | 1.544 MHz reference |
| ref_2m048 | input | 1 | 2.048 MHz reference |
| ref_8m192 | input | 1 | 8.192 MHz reference |
| port_rclk | input | 4 | Recovered receive clock per port |
| port_bpclk | input | 4 | Backplane clock per port |
| port_rsync_in | input | 4 | Receive sync seen at each framer |
| port_tsync_in | input | 4 | Transmit sync seen at each framer |
| port_rser | input | 4 | Receive serial data per port |
| pcm_txd | input | 1 | PCM bus transmit data |
| mclk_out | output | 2 | Master clocks for port pairs (1,3) and (2,4) |
| port_tclk | output | 4 | Transmit clock per port |
| port_tsysclk | output | 4 | Transmit system clock per port |
| port_rsysclk | output | 4 | Receive system clock per port |
| port_tsync_out | output | 4 | Transmit sync drive value |
| port_tsync_oe | output | 4 | Transmit sync drive enable |
| port_tssync_out | output | 4 | Elastic-store sync drive value |
| port_tssync_oe | output | 4 | Elastic-store sync drive enable |
| port_rsync_out | output | 4 | Receive sync drive value |
| port_rsync_oe | output | 4 | Receive sync drive enable |
| port_tser_out | output | 4 | Transmit serial data drive value |
| port_tser_oe | output | 4 | Transmit serial data drive enable |
| pcm_rxd | output | 1 | PCM bus receive data |
| pcm_rsync | output | 1 | PCM bus receive sync |
| pcm_tsync | output | 1 | PCM bus transmit sync |
| pcm_rclk | output | 1 | PCM bus receive clock |
| pcm_tclk | output | 1 | PCM bus transmit clock |

## Verification
Each routing output is combinational from the configuration, so a corrupted configuration bit shows up at once. The affected output follows the wrong reference or port, or an enable flips. A selector that lands on the wrong source can be told apart only if that source toggles differently from the correct one, so the stimulus gives every clock and data input its own bit pattern and also its complement. A fault in the register decode shows one clock later: a masked readback value is wrong, or a write to an identity or undefined offset disturbs a route.

// File: rtl/sync_route_pkg.sv
`timescale 1ns/1ps
package sync_route_pkg;
  localparam int NUM_PORTS = 4;
  localparam int PSEL_W    = $clog2(NUM_PORTS);
  localparam int NUM_MCLK  = 2;
  localparam int CODE_W    = 2;
  localparam int BYTE_W    = 8;

  localparam logic [7:0] OFS_ID      = 8'h00;
  localparam logic [7:0] OFS_XID_HI  = 8'h02;
  localparam logic [7:0] OFS_XID_MID = 8'h03;
  localparam logic [7:0] OFS_XID_LO  = 8'h04;
  localparam logic [7:0] OFS_BREV    = 8'h05;
  localparam logic [7:0] OFS_AREV    = 8'h06;
  localparam logic [7:0] OFS_LREV    = 8'h07;
  localparam logic [7:0] OFS_MCLK    = 8'h11;
  localparam logic [7:0] OFS_TCLK    = 8'h12;
  localparam logic [7:0] OFS_TSYS    = 8'h13;
  localparam logic [7:0] OFS_RSYS    = 8'h14;
  localparam logic [7:0] OFS_TSYNC   = 8'h15;
  localparam logic [7:0] OFS_TSSYNC  = 8'h16;
  localparam logic [7:0] OFS_RSYNC   = 8'h17;
  localparam logic [7:0] OFS_TSER    = 8'h18;
  localparam logic [7:0] OFS_PRXD    = 8'h19;
  localparam logic [7:0] OFS_PSYNC   = 8'h1A;
  localparam logic [7:0] OFS_PCLK    = 8'h1B;

  typedef enum logic [CODE_W-1:0] {
    TXC_T1 = 2'b00, TXC_E1 = 2'b01, TXC_RECOVERED = 2'b10, TXC_SPARE = 2'b11
  } txclk_code_e;

  typedef enum logic [CODE_W-1:0] {
    SYS_T1 = 2'b00, SYS_E1 = 2'b01, SYS_FAST = 2'b10, SYS_BACKPLANE = 2'b11
  } sysclk_code_e;

  typedef enum logic [CODE_W-1:0] {
    SER_FLOAT = 2'b00, SER_LOOP = 2'b01, SER_PCM = 2'b10, SER_SPARE = 2'b11
  } ser_code_e;

  typedef struct packed {
    logic [NUM_MCLK-1:0]                 mclk_sel;
    logic [NUM_PORTS-1:0][CODE_W-1:0]    tclk_code;
    logic [NUM_PORTS-1:0][CODE_W-1:0]    tsys_code;
    logic [NUM_PORTS-1:0][CODE_W-1:0]    rsys_code;
    logic [NUM_PORTS-1:0][CODE_W-1:0]    tser_code;
    logic [NUM_PORTS-1:0]                tsync_en;
    logic [NUM_PORTS-1:0]                tssync_en;
    logic [NUM_PORTS-1:0]                rsync_en;
    logic [NUM_PORTS-1:0]                prxd_en;
    logic [PSEL_W-1:0]                   rsync_master;
    logic [PSEL_W-1:0]                   pcm_rsync_sel;
    logic [PSEL_W-1:0]                   pcm_tsync_sel;
    logic [PSEL_W:0]                     pcm_rclk_code;
    logic [PSEL_W:0]                     pcm_tclk_code;
  } route_cfg_t;

  function automatic route_cfg_t cfg_reset();
    route_cfg_t c;
    c = '0;
    c.mclk_sel = '1;
    return c;
  endfunction
endpackage

// File: rtl/srm_regs.sv
`timescale 1ns/1ps
module srm_regs
  import sync_route_pkg::*;
#(
  parameter logic [3:0] BOARD_REV = 4'h1,
  parameter logic [3:0] ASSY_REV  = 4'h2,
  parameter logic [3:0] LOGIC_REV = 4'h3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] addr,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output route_cfg_t        cfg,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= cfg_reset();
    end else if (we) begin
      case (addr)
        OFS_MCLK:   cfg.mclk_sel  <= wdata[NUM_MCLK-1:0];
        OFS_TCLK:   cfg.tclk_code <= wdata;
        OFS_TSYS:   cfg.tsys_code <= wdata;
        OFS_RSYS:   cfg.rsys_code <= wdata;
        OFS_TSYNC:  cfg.tsync_en  <= wdata[NUM_PORTS-1:0];
        OFS_TSSYNC: cfg.tssync_en <= wdata[NUM_PORTS-1:0];
        OFS_RSYNC: begin
          cfg.rsync_en     <= wdata[NUM_PORTS-1:0];
          cfg.rsync_master <= wdata[5:4];
        end
        OFS_TSER:   cfg.tser_code <= wdata;
        OFS_PRXD:   cfg.prxd_en   <= wdata[NUM_PORTS-1:0];
        OFS_PSYNC: begin
          cfg.pcm_rsync_sel <= wdata[1:0];
          cfg.pcm_tsync_sel <= wdata[5:4];
        end
        OFS_PCLK: begin
          cfg.pcm_rclk_code <= wdata[2:0];
          cfg.pcm_tclk_code <= wdata[6:4];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_ID:      rd_mux = 8'h0D;
      OFS_XID_HI:  rd_mux = 8'h00;
      OFS_XID_MID: rd_mux = 8'h01;
      OFS_XID_LO:  rd_mux = 8'h06;
      OFS_BREV:    rd_mux = {4'h0, BOARD_REV};
      OFS_AREV:    rd_mux = {4'h0, ASSY_REV};
      OFS_LREV:    rd_mux = {4'h0, LOGIC_REV};
      OFS_MCLK:    rd_mux = {6'h00, cfg.mclk_sel};
      OFS_TCLK:    rd_mux = cfg.tclk_code;
      OFS_TSYS:    rd_mux = cfg.tsys_code;
      OFS_RSYS:    rd_mux = cfg.rsys_code;
      OFS_TSYNC:   rd_mux = {4'h0, cfg.tsync_en};
      OFS_TSSYNC:  rd_mux = {4'h0, cfg.tssync_en};
      OFS_RSYNC:   rd_mux = {2'b00, cfg.rsync_master, cfg.rsync_en};
      OFS_TSER:    rd_mux = cfg.tser_code;
      OFS_PRXD:    rd_mux = {4'h0, cfg.prxd_en};
      OFS_PSYNC:   rd_mux = {2'b00, cfg.pcm_tsync_sel, 2'b00, cfg.pcm_rsync_sel};
      OFS_PCLK:    rd_mux = {1'b0, cfg.pcm_tclk_code, 1'b0, cfg.pcm_rclk_code};
      default:     rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/srm_port_mux.sv
`timescale 1ns/1ps
module srm_port_mux
  import sync_route_pkg::*;
(
  input  logic              ref_t1,
  input  logic              ref_e1,
  input  logic              ref_fast,
  input  logic              rclk,
  input  logic              bpclk,
  input  logic              rsync_own,
  input  logic              rsync_master,
  input  logic              rser,
  input  logic              pcm_txd,
  input  logic [CODE_W-1:0] tclk_code,
  input  logic [CODE_W-1:0] tsys_code,
  input  logic [CODE_W-1:0] rsys_code,
  input  logic [CODE_W-1:0] tser_code,
  input  logic              tsync_en,
  input  logic              tssync_en,
  input  logic              rsync_en,
  output logic              tclk,
  output logic              tsysclk,
  output logic              rsysclk,
  output logic              tsync_o,
  output logic              tsync_oe,
  output logic              tssync_o,
  output logic              tssync_oe,
  output logic              rsync_o,
  output logic              rsync_oe,
  output logic              tser_o,
  output logic              tser_oe
);
  function automatic logic sys_pick(logic [CODE_W-1:0] code, logic a, logic b,
                                    logic c, logic d);
    case (code)
      SYS_T1:   return a;
      SYS_E1:   return b;
      SYS_FAST: return c;
      default:  return d;
    endcase
  endfunction

  always_comb begin
    case (tclk_code)
      TXC_T1:        tclk = ref_t1;
      TXC_E1:        tclk = ref_e1;
      TXC_RECOVERED: tclk = rclk;
      default:       tclk = 1'b0;
    endcase
  end

  assign tsysclk = sys_pick(tsys_code, ref_t1, ref_e1, ref_fast, bpclk);
  assign rsysclk = sys_pick(rsys_code, ref_t1, ref_e1, ref_fast, bpclk);

  assign tsync_oe  = tsync_en;
  assign tsync_o   = tsync_en & rsync_own;
  assign tssync_oe = tssync_en;
  assign tssync_o  = tssync_en & rsync_own;
  assign rsync_oe  = rsync_en;
  assign rsync_o   = rsync_en & rsync_master;

  always_comb begin
    case (tser_code)
      SER_LOOP: begin tser_o = rser;    tser_oe = 1'b1; end
      SER_PCM:  begin tser_o = pcm_txd; tser_oe = 1'b1; end
      default:  begin tser_o = 1'b0;    tser_oe = 1'b0; end
    endcase
  end
endmodule

// File: rtl/srm_pcm_mux.sv
`timescale 1ns/1ps
module srm_pcm_mux
  import sync_route_pkg::*;
(
  input  logic [NUM_PORTS-1:0] rclk,
  input  logic [NUM_PORTS-1:0] bpclk,
  input  logic [NUM_PORTS-1:0] tclk_sel,
  input  logic [NUM_PORTS-1:0] rsync_in,
  input  logic [NUM_PORTS-1:0] tsync_in,
  input  logic [NUM_PORTS-1:0] rser,
  input  logic [NUM_PORTS-1:0] prxd_en,
  input  logic [PSEL_W-1:0]    rsync_sel,
  input  logic [PSEL_W-1:0]    tsync_sel,
  input  logic [PSEL_W:0]      rclk_code,
  input  logic [PSEL_W:0]      tclk_code,
  output logic                 pcm_rxd,
  output logic                 pcm_rsync,
  output logic                 pcm_tsync,
  output logic                 pcm_rclk,
  output logic                 pcm_tclk
);
  logic [PSEL_W-1:0] rclk_port, tclk_port;

  assign rclk_port = rclk_code[PSEL_W-1:0];
  assign tclk_port = tclk_code[PSEL_W-1:0];

  assign pcm_rxd   = |(rser & prxd_en);
  assign pcm_rsync = rsync_in[rsync_sel];
  assign pcm_tsync = tsync_in[tsync_sel];
  assign pcm_rclk  = rclk_code[PSEL_W] ? bpclk[rclk_port] : rclk[rclk_port];
  assign pcm_tclk  = tclk_code[PSEL_W] ? bpclk[tclk_port] : tclk_sel[tclk_port];
endmodule

// File: rtl/sync_route_matrix.sv
`timescale 1ns/1ps
module sync_route_matrix
  import sync_route_pkg::*;
#(
  parameter logic [3:0] BOARD_REV = 4'h1,
  parameter logic [3:0] ASSY_REV  = 4'h2,
  parameter logic [3:0] LOGIC_REV = 4'h3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BYTE_W-1:0]    host_addr,
  input  logic                 host_we,
  input  logic [BYTE_W-1:0]    host_wdata,
  output logic [BYTE_W-1:0]    host_rdata,
  input  logic                 ref_1m544,
  input  logic                 ref_2m048,
  input  logic                 ref_8m192,
  input  logic [NUM_PORTS-1:0] port_rclk,
  input  logic [NUM_PORTS-1:0] port_bpclk,
  input  logic [NUM_PORTS-1:0] port_rsync_in,
  input  logic [NUM_PORTS-1:0] port_tsync_in,
  input  logic [NUM_PORTS-1:0] port_rser,
  input  logic                 pcm_txd,
  output logic [NUM_MCLK-1:0]  mclk_out,
  output logic [NUM_PORTS-1:0] port_tclk,
  output logic [NUM_PORTS-1:0] port_tsysclk,
  output logic [NUM_PORTS-1:0] port_rsysclk,
  output logic [NUM_PORTS-1:0] port_tsync_out,
  output logic [NUM_PORTS-1:0] port_tsync_oe,
  output logic [NUM_PORTS-1:0] port_tssync_out,
  output logic [NUM_PORTS-1:0] port_tssync_oe,
  output logic [NUM_PORTS-1:0] port_rsync_out,
  output logic [NUM_PORTS-1:0] port_rsync_oe,
  output logic [NUM_PORTS-1:0] port_tser_out,
  output logic [NUM_PORTS-1:0] port_tser_oe,
  output logic                 pcm_rxd,
  output logic                 pcm_rsync,
  output logic                 pcm_tsync,
  output logic                 pcm_rclk,
  output logic                 pcm_tclk
);
  route_cfg_t cfg;
  logic       master_rsync;

  srm_regs #(
    .BOARD_REV(BOARD_REV), .ASSY_REV(ASSY_REV), .LOGIC_REV(LOGIC_REV)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(host_addr), .we(host_we),
    .wdata(host_wdata), .cfg(cfg), .rdata(host_rdata)
  );

  for (genvar g = 0; g < NUM_MCLK; g++) begin : g_mclk
    assign mclk_out[g] = cfg.mclk_sel[g] ? ref_2m048 : ref_1m544;
  end

  assign master_rsync = port_rsync_in[cfg.rsync_master];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    srm_port_mux u_mux (
      .ref_t1(ref_1m544), .ref_e1(ref_2m048), .ref_fast(ref_8m192),
      .rclk(port_rclk[p]), .bpclk(port_bpclk[p]),
      .rsync_own(port_rsync_in[p]), .rsync_master(master_rsync),
      .rser(port_rser[p]), .pcm_txd(pcm_txd),
      .tclk_code(cfg.tclk_code[p]), .tsys_code(cfg.tsys_code[p]),
      .rsys_code(cfg.rsys_code[p]), .tser_code(cfg.tser_code[p]),
      .tsync_en(cfg.tsync_en[p]), .tssync_en(cfg.tssync_en[p]),
      .rsync_en(cfg.rsync_en[p]),
      .tclk(port_tclk[p]), .tsysclk(port_tsysclk[p]), .rsysclk(port_rsysclk[p]),
      .tsync_o(port_tsync_out[p]), .tsync_oe(port_tsync_oe[p]),
      .tssync_o(port_tssync_out[p]), .tssync_oe(port_tssync_oe[p]),
      .rsync_o(port_rsync_out[p]), .rsync_oe(port_rsync_oe[p]),
      .tser_o(port_tser_out[p]), .tser_oe(port_tser_oe[p])
    );
  end

  srm_pcm_mux u_pcm (
    .rclk(port_rclk), .bpclk(port_bpclk), .tclk_sel(port_tclk),
    .rsync_in(port_rsync_in), .tsync_in(port_tsync_in), .rser(port_rser),
    .prxd_en(cfg.prxd_en), .rsync_sel(cfg.pcm_rsync_sel),
    .tsync_sel(cfg.pcm_tsync_sel), .rclk_code(cfg.pcm_rclk_code),
    .tclk_code(cfg.pcm_tclk_code),
    .pcm_rxd(pcm_rxd), .pcm_rsync(pcm_rsync), .pcm_tsync(pcm_tsync),
    .pcm_rclk(pcm_rclk), .pcm_tclk(pcm_tclk)
  );
endmodule

// File: rtl/sync_route_matrix_chk.sv
`timescale 1ns/1ps
module sync_route_matrix_chk
  import sync_route_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic [BYTE_W-1:0]    host_addr,
  input logic                 host_we,
  input logic [BYTE_W-1:0]    host_wdata,
  input logic [BYTE_W-1:0]    host_rdata,
  input logic                 ref_2m048,
  input logic [NUM_MCLK-1:0]  mclk_out,
  input logic [NUM_PORTS-1:0] port_tsync_oe,
  input logic [NUM_PORTS-1:0] port_rsync_oe,
  input logic [NUM_PORTS-1:0] port_tser_oe,
  input logic [NUM_PORTS-1:0] prxd_en,
  input logic                 pcm_rxd
);
  logic seen_rst = 1'b0;
  logic live     = 1'b0;

  always_ff @(posedge clk) begin
    seen_rst <= seen_rst | rst;
    live     <= seen_rst & ~rst;
  end

  // R1: identity value appears one edge after its address
  assert_id_read_R1: assert property (@(posedge clk) disable iff (rst)
    (live && $past(host_addr) == OFS_ID) |-> host_rdata == 8'h0D);

  // R2: a hole in the map reads as zero
  assert_undef_read_R2: assert property (@(posedge clk) disable iff (rst)
    (live && $past(host_addr) == 8'h08) |-> host_rdata == 8'h00);

  // R4: leaving reset selects the 2.048 MHz reference on both master clocks
  assert_mclk_reset_R4: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && $past(rst)) |-> mclk_out == {NUM_MCLK{ref_2m048}});

  // R7: transmit sync enables follow the written bits
  assert_tsync_write_R7: assert property (@(posedge clk) disable iff (rst)
    (live && $past(host_we) && $past(host_addr) == OFS_TSYNC)
      |-> port_tsync_oe == $past(host_wdata[NUM_PORTS-1:0]));

  // R8: receive sync enables follow the written bits
  assert_rsync_write_R8: assert property (@(posedge clk) disable iff (rst)
    (live && $past(host_we) && $past(host_addr) == OFS_RSYNC)
      |-> port_rsync_oe == $past(host_wdata[NUM_PORTS-1:0]));

  // R9: serial data is driven only for the loop and PCM codes
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tser
    assert_tser_write_R9: assert property (@(posedge clk) disable iff (rst)
      (live && $past(host_we) && $past(host_addr) == OFS_TSER)
        |-> port_tser_oe[p] == ($past(host_wdata[2*p+:2]) == 2'b01 ||
                                $past(host_wdata[2*p+:2]) == 2'b10));
  end

  // R10: no enabled port means the PCM receive line stays low
  assert_pcm_rxd_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (prxd_en == '0) |-> !pcm_rxd);
endmodule

bind sync_route_matrix sync_route_matrix_chk u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .ref_2m048(ref_2m048),
  .mclk_out(mclk_out), .port_tsync_oe(port_tsync_oe),
  .port_rsync_oe(port_rsync_oe), .port_tser_oe(port_tser_oe),
  .prxd_en(cfg.prxd_en), .pcm_rxd(pcm_rxd)
);

// File: tb/sync_route_matrix_tb.sv
`timescale 1ns/1ps
module sync_route_matrix_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst;
  logic [7:0] host_addr, host_wdata;
  logic       host_we;
  wire  [7:0] host_rdata;
  logic       r1, r2, r8, ptxd;
  logic [3:0] rclk, bp, rsi, tsi, rser;
  wire  [1:0] mclk;
  wire  [3:0] tclk, tsys, rsys, ts_o, ts_oe, tss_o, tss_oe, rs_o, rs_oe, tser_o, tser_oe;
  wire        p_rxd, p_rsync, p_tsync, p_rclk, p_tclk;

  sync_route_matrix dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ref_1m544(r1), .ref_2m048(r2), .ref_8m192(r8),
    .port_rclk(rclk), .port_bpclk(bp), .port_rsync_in(rsi),
    .port_tsync_in(tsi), .port_rser(rser), .pcm_txd(ptxd),
    .mclk_out(mclk), .port_tclk(tclk), .port_tsysclk(tsys), .port_rsysclk(rsys),
    .port_tsync_out(ts_o), .port_tsync_oe(ts_oe),
    .port_tssync_out(tss_o), .port_tssync_oe(tss_oe),
    .port_rsync_out(rs_o), .port_rsync_oe(rs_oe),
    .port_tser_out(tser_o), .port_tser_oe(tser_oe),
    .pcm_rxd(p_rxd), .pcm_rsync(p_rsync), .pcm_tsync(p_tsync),
    .pcm_rclk(p_rclk), .pcm_tclk(p_tclk)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench's own picture of the control registers
  logic [1:0] m_mclk;
  logic [7:0] m_tclk, m_tsys, m_rsys, m_tser;
  logic [3:0] m_ts, m_tss, m_rsen, m_prx;
  logic [1:0] m_rsm, m_prs, m_pts;
  logic [2:0] m_prc, m_ptc;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shadow_reset();
    m_mclk = 2'b11; m_tclk = 0; m_tsys = 0; m_rsys = 0; m_tser = 0;
    m_ts = 0; m_tss = 0; m_rsen = 0; m_prx = 0;
    m_rsm = 0; m_prs = 0; m_pts = 0; m_prc = 0; m_ptc = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
    case (a)
      8'h11: m_mclk = d[1:0];
      8'h12: m_tclk = d;
      8'h13: m_tsys = d;
      8'h14: m_rsys = d;
      8'h15: m_ts = d[3:0];
      8'h16: m_tss = d[3:0];
      8'h17: begin m_rsen = d[3:0]; m_rsm = d[5:4]; end
      8'h18: m_tser = d;
      8'h19: m_prx = d[3:0];
      8'h1A: begin m_prs = d[1:0]; m_pts = d[5:4]; end
      8'h1B: begin m_prc = d[2:0]; m_ptc = d[6:4]; end
      default: ;
    endcase
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    chk(tag, 32'(host_rdata), 32'(exp));
  endtask

  function automatic logic sys_exp(logic [1:0] c, int i);
    case (c)
      2'b00: return r1;
      2'b01: return r2;
      2'b10: return r8;
      default: return bp[i];
    endcase
  endfunction

  task automatic compare_all();
    logic [1:0] e_mclk;
    logic [3:0] e_tclk, e_tsys, e_rsys, e_ts, e_tss, e_rs, e_to, e_toe;
    for (int g = 0; g < 2; g++) e_mclk[g] = m_mclk[g] ? r2 : r1;
    for (int i = 0; i < 4; i++) begin
      case (m_tclk[2*i+:2])
        2'b00: e_tclk[i] = r1;
        2'b01: e_tclk[i] = r2;
        2'b10: e_tclk[i] = rclk[i];
        default: e_tclk[i] = 1'b0;
      endcase
      e_tsys[i] = sys_exp(m_tsys[2*i+:2], i);
      e_rsys[i] = sys_exp(m_rsys[2*i+:2], i);
      e_ts[i]   = m_ts[i] & rsi[i];
      e_tss[i]  = m_tss[i] & rsi[i];
      e_rs[i]   = m_rsen[i] & rsi[m_rsm];
      case (m_tser[2*i+:2])
        2'b01: begin e_to[i] = rser[i]; e_toe[i] = 1'b1; end
        2'b10: begin e_to[i] = ptxd;    e_toe[i] = 1'b1; end
        default: begin e_to[i] = 1'b0;  e_toe[i] = 1'b0; end
      endcase
    end
    chk("R4 mclk", 32'(mclk), 32'(e_mclk));
    chk("R5 tclk", 32'(tclk), 32'(e_tclk));
    chk("R6 tsysclk", 32'(tsys), 32'(e_tsys));
    chk("R6 rsysclk", 32'(rsys), 32'(e_rsys));
    chk("R7 tsync", {ts_oe, ts_o}, {m_ts, e_ts});
    chk("R7 tssync", {tss_oe, tss_o}, {m_tss, e_tss});
    chk("R8 rsync", {rs_oe, rs_o}, {m_rsen, e_rs});
    chk("R9 tser", {tser_oe, tser_o}, {e_toe, e_to});
    chk("R10 pcm_rxd", 32'(p_rxd), 32'(|(rser & m_prx)));
    chk("R11 pcm_sync", {p_rsync, p_tsync}, {rsi[m_prs], tsi[m_pts]});
    chk("R12 pcm_rclk", 32'(p_rclk), 32'(m_prc[2] ? bp[m_prc[1:0]] : rclk[m_prc[1:0]]));
    chk("R12 pcm_tclk", 32'(p_tclk), 32'(m_ptc[2] ? bp[m_ptc[1:0]] : e_tclk[m_ptc[1:0]]));
  endtask

  // each input gets its own bit pattern; odd steps use the complement
  task automatic sweep(int seed);
    for (int k = 0; k < 6; k++) begin
      logic [31:0] base;
      logic [26:0] v;
      base = (32'(seed) * 32'h9E3779B1) ^ (32'(k / 2) * 32'h85EBCA6B) ^ 32'h2C1B3C6D;
      v = k[0] ? ~base[26:0] : base[26:0];
      @(negedge clk);
      {r1, r2, r8, ptxd, rclk, bp, rsi, tsi, rser} = v;
      #2;
      compare_all();
    end
  endtask

  task automatic t_reset();
    shadow_reset();
    rst = 1'b1; host_we = 1'b0; host_addr = 0; host_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 rdata during reset", 32'(host_rdata), 32'h0);
    rst = 1'b0;
    rd_chk(8'h11, 8'h03, "R3 mclk reset");
    for (int a = 8'h12; a <= 8'h1B; a++) rd_chk(8'(a), 8'h00, "R3 ctrl reset");
    sweep(1);
  endtask

  task automatic t_ids();
    rd_chk(8'h00, 8'h0D, "R1 id");
    rd_chk(8'h02, 8'h00, "R1 xid hi");
    rd_chk(8'h03, 8'h01, "R1 xid mid");
    rd_chk(8'h04, 8'h06, "R1 xid lo");
    rd_chk(8'h05, 8'h01, "R1 board rev");
    rd_chk(8'h06, 8'h02, "R1 assy rev");
    rd_chk(8'h07, 8'h03, "R1 logic rev");
    wr(8'h00, 8'hFF); wr(8'h04, 8'h00);
    rd_chk(8'h00, 8'h0D, "R1 id after write");
    rd_chk(8'h04, 8'h06, "R1 xid lo after write");
    sweep(2);
  endtask

  task automatic t_undef();
    wr(8'h01, 8'hFF); wr(8'h08, 8'hFF); wr(8'h10, 8'hFF); wr(8'h1C, 8'hFF); wr(8'hFF, 8'hFF);
    rd_chk(8'h01, 8'h00, "R2 undef 01");
    rd_chk(8'h08, 8'h00, "R2 undef 08");
    rd_chk(8'h10, 8'h00, "R2 undef 10");
    rd_chk(8'h1C, 8'h00, "R2 undef 1C");
    rd_chk(8'hFF, 8'h00, "R2 undef FF");
    sweep(3);
  endtask

  task automatic t_readback();
    logic [7:0] masks [12];
    masks = '{8'h03, 8'hFF, 8'hFF, 8'hFF, 8'h0F, 8'h0F, 8'h3F, 8'hFF, 8'h0F, 8'h33, 8'h77, 8'h00};
    for (int i = 0; i < 11; i++) begin
      wr(8'(8'h11 + i), 8'hFF);
      rd_chk(8'(8'h11 + i), masks[i], "R3 readback mask");
    end
    sweep(4);
    for (int i = 0; i < 11; i++) wr(8'(8'h11 + i), 8'h00);
  endtask

  task automatic t_mclk();
    for (int v = 0; v < 4; v++) begin wr(8'h11, 8'(v)); sweep(10 + v); end
  endtask

  task automatic t_tclk();
    logic [7:0] pats [5];
    pats = '{8'h00, 8'h55, 8'hAA, 8'hFF, 8'hE4};
    for (int i = 0; i < 5; i++) begin wr(8'h12, pats[i]); sweep(20 + i); end
  endtask

  task automatic t_sysclk();
    logic [7:0] pats [4];
    pats = '{8'hE4, 8'h1B, 8'hFF, 8'hAA};
    for (int i = 0; i < 4; i++) begin
      wr(8'h13, pats[i]); wr(8'h14, pats[3 - i]); sweep(30 + i);
    end
  endtask

  task automatic t_sync();
    for (int v = 0; v < 16; v += 5) begin
      wr(8'h15, 8'(v)); wr(8'h16, 8'(15 - v)); sweep(40 + v);
    end
  endtask

  task automatic t_rsync();
    for (int m = 0; m < 4; m++) begin
      wr(8'h17, 8'((m << 4) | 4'hF)); sweep(60 + m);
      wr(8'h17, 8'((m << 4) | 4'h5)); sweep(70 + m);
    end
    wr(8'h17, 8'h30); sweep(79);
  endtask

  task automatic t_tser();
    logic [7:0] pats [4];
    pats = '{8'hE4, 8'h1B, 8'hFF, 8'h00};
    for (int i = 0; i < 4; i++) begin wr(8'h18, pats[i]); sweep(80 + i); end
  endtask

  task automatic t_pcm_data();
    for (int v = 0; v < 16; v++) begin wr(8'h19, 8'(v)); sweep(90 + v); end
  endtask

  task automatic t_pcm_sync();
    for (int v = 0; v < 16; v++) begin
      wr(8'h1A, 8'(((v >> 2) << 4) | (v & 3))); sweep(110 + v);
    end
  endtask

  task automatic t_pcm_clk();
    wr(8'h12, 8'hE4);
    for (int v = 0; v < 8; v++) begin
      wr(8'h1B, 8'(((7 - v) << 4) | v)); sweep(130 + v);
    end
    wr(8'h1B, 8'h44); sweep(140);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_ids();
    t_undef();
    t_readback();
    t_mclk();
    t_tclk();
    t_sysclk();
    t_sync();
    t_rsync();
    t_tser();
    t_pcm_data();
    t_pcm_sync();
    t_pcm_clk();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule